// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and two frame clocks, one for the transmit side and one for the receive side, of a serial audio link from a faster master clock. Each divider is programmable. When the block is clock master, an 8-bit bit-clock divider sets how many master cycles make one bit-clock period. Two separate 8-bit frame dividers set how many bit clocks make one transmit frame and one receive frame. All three fields hold the wanted count minus one. For 48 kHz audio carried in two 32-bit slots, the bit clock runs at 64 times the sample rate and each frame divider is programmed to 63.

A mode input makes the block clock slave. In that mode the clock pins become inputs and the dividers stop. The external bit and frame clocks are resynchronised into the master clock domain, and the block only reports their edges. A 2-bit sharing field can make both directions use one frame clock.

In both modes the block gives the serial data formatter single-cycle strobes. One strobe marks each rising and each falling bit-clock edge, and one marks every change of each frame clock. Each strobe lines up with the first master cycle in which the new clock level is visible on the outputs.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is asserted, bclk_out, tx_fclk_out, rx_fclk_out and all four strobes are 0.
- R2: In master mode with bclk_div = N (N at least 1), the bit clock has a period of N+1 master cycles. It is low for floor((N+1)/2) cycles and high for the rest, so an odd ratio gives the longer high phase. Counting starts low from the release of reset.
- R3: bclk_rise and bclk_fall are each high for exactly one cycle. That cycle is the first one in which bclk_out shows its new level.
- R4: In master mode with a frame divider F (F at least 1) and M = F+1, the frame clock starts low. It stays low for floor(M/2) bit-clock falling edges, is high for the remaining M - floor(M/2), and then repeats. It changes one master cycle after a bclk_fall strobe. Each change raises the matching frame strobe for one cycle.
- R5: With share_sel = 0, the transmit frame clock uses tx_frame_div and the receive frame clock uses rx_frame_div, and each runs on its own.
- R6: With share_sel = 1 or 3, the receive frame output and its strobe follow the transmit frame clock. With share_sel = 2, the transmit frame output and its strobe follow the receive frame clock.
- R7: clk_oe is 1 in master mode and 0 in slave mode (slave_mode = 1). In slave mode each of bclk_in, tx_fclk_in and rx_fclk_in passes through two synchronising flip-flops. A change driven before master edge 1 shows on the matching output and strobe after edge 3.
- R8: In slave mode the divider fields have no effect. The frame outputs change only when the external frame inputs change, even while the bit clock is toggling.
- R9: With frame dividers of 63, each frame is 64 bit clocks long: 32 low and 32 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: clocks are taken from the pins; 0: the block generates them |
| bclk_div | input | 8 | Master cycles per bit clock, minus one |
| tx_frame_div | input | 8 | Bit clocks per transmit frame, minus one |
| rx_frame_div | input | 8 | Bit clocks per receive frame, minus one |
| share_sel | input | 2 | 0 independent, 1/3 receive follows transmit, 2 transmit follows receive |
| bclk_in | input | 1 | External bit clock (slave mode) |
| tx_fclk_in | input | 1 | External transmit frame clock (slave mode) |
| rx_fclk_in | input | 1 | External receive frame clock (slave mode) |
| clk_oe | output | 1 | Output enable for the clock pins |
| bclk_out | output | 1 | Bit clock level |
| tx_fclk_out | output | 1 | Transmit frame clock level |
| rx_fclk_out | output | 1 | Receive frame clock level |
| bclk_rise | output | 1 | One-cycle strobe on a rising bit-clock edge |
| bclk_fall | output | 1 | One-cycle strobe on a falling bit-clock edge |
| tx_fclk_edge | output | 1 | One-cycle strobe on any transmit frame clock change |
| rx_fclk_edge | output | 1 | One-cycle strobe on any receive frame clock change |

## Verification
The bench sweeps the bit-clock divider over every value from 1 to 12. Even and odd ratios show whether the extra master cycle goes to the high phase. Small frame dividers are swept against one another with unequal transmit and receive values, which shows any crossing of the two counters. The full 63 setting checks the 32/32 split. The three sharing codes are each run with unequal dividers, so a wrong routing direction shows as a different frame length. In slave mode, toggling one external pin at a time shows whether the three-edge latency is right and whether any divider still has an effect.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic [DIV_W-1:0] bclk_div,
  input  logic [DIV_W-1:0] tx_frame_div,
  input  logic [DIV_W-1:0] rx_frame_div,
  input  logic [SEL_W-1:0] share_sel,
  input  logic             bclk_in,
  input  logic             tx_fclk_in,
  input  logic             rx_fclk_in,
  output logic             clk_oe,
  output logic             bclk_out,
  output logic             tx_fclk_out,
  output logic             rx_fclk_out,
  output logic             bclk_rise,
  output logic             bclk_fall,
  output logic             tx_fclk_edge,
  output logic             rx_fclk_edge
);

  logic [DIV_W-1:0] bcnt, bcnt_nx, tx_cnt, tx_nx, rx_cnt, rx_nx;
  logic [DIV_W:0]   b_len, tx_len, rx_len;
  logic [DIV_W-1:0] b_low, tx_low, rx_low;
  logic [2:0]       sync1, sync2;
  logic             bclk_q, bclk_p, tx_q, rx_q, tx_p, rx_p;
  logic             tx_fin, rx_fin;

  // low phase = floor(ratio / 2)
  assign b_len  = {1'b0, bclk_div} + 1'b1;
  assign tx_len = {1'b0, tx_frame_div} + 1'b1;
  assign rx_len = {1'b0, rx_frame_div} + 1'b1;
  assign b_low  = b_len[DIV_W:1];
  assign tx_low = tx_len[DIV_W:1];
  assign rx_low = rx_len[DIV_W:1];

  assign bcnt_nx = (bcnt >= bclk_div) ? '0 : bcnt + 1'b1;
  assign tx_nx   = !bclk_fall ? tx_cnt : (tx_cnt >= tx_frame_div) ? '0 : tx_cnt + 1'b1;
  assign rx_nx   = !bclk_fall ? rx_cnt : (rx_cnt >= rx_frame_div) ? '0 : rx_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      bcnt   <= '0;
      tx_cnt <= '0;
      rx_cnt <= '0;
      bclk_q <= 1'b0;
      bclk_p <= 1'b0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      tx_p   <= 1'b0;
      rx_p   <= 1'b0;
    end else begin
      sync1  <= {rx_fclk_in, tx_fclk_in, bclk_in};
      sync2  <= sync1;
      bclk_p <= bclk_q;
      tx_p   <= tx_fin;
      rx_p   <= rx_fin;
      if (slave_mode) begin
        bcnt   <= '0;
        tx_cnt <= '0;
        rx_cnt <= '0;
        bclk_q <= sync2[0];
        tx_q   <= sync2[1];
        rx_q   <= sync2[2];
      end else begin
        bcnt   <= bcnt_nx;
        tx_cnt <= tx_nx;
        rx_cnt <= rx_nx;
        bclk_q <= (bcnt_nx >= b_low);
        tx_q   <= (tx_nx >= tx_low);
        rx_q   <= (rx_nx >= rx_low);
      end
    end
  end

  assign tx_fin = (share_sel == SEL_W'(2)) ? rx_q : tx_q;
  assign rx_fin = (share_sel == SEL_W'(1) || share_sel == SEL_W'(3)) ? tx_q : rx_q;

  assign clk_oe       = ~slave_mode;
  assign bclk_out     = bclk_q;
  assign tx_fclk_out  = tx_fin;
  assign rx_fclk_out  = rx_fin;
  assign bclk_rise    = bclk_q & ~bclk_p;
  assign bclk_fall    = ~bclk_q & bclk_p;
  assign tx_fclk_edge = tx_fin ^ tx_p;
  assign rx_fclk_edge = rx_fin ^ rx_p;

  // R2
  rise_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $past(!slave_mode) && bclk_rise && bclk_div != '0) |-> bcnt == b_low);

  // R2
  fall_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $past(!slave_mode) && bclk_fall) |-> bcnt == '0);

  // R4
  frame_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !$past(slave_mode) && !$past(slave_mode, 2) && tx_fclk_edge)
      |-> $past(bclk_fall));

  // R8
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> (bcnt == '0 && tx_cnt == '0 && rx_cnt == '0));

endmodule

// File: tb/audio_clkgen_test.sv
module audio_clkgen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic [7:0] bclk_div = 8'd1, tx_frame_div = 8'd1, rx_frame_div = 8'd1;
  logic [1:0] share_sel = 2'd0;
  logic bclk_in = 1'b0, tx_fclk_in = 1'b0, rx_fclk_in = 1'b0;
  logic clk_oe, bclk_out, tx_fclk_out, rx_fclk_out;
  logic bclk_rise, bclk_fall, tx_fclk_edge, rx_fclk_edge;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  audio_clkgen uut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .bclk_div(bclk_div), .tx_frame_div(tx_frame_div), .rx_frame_div(rx_frame_div),
    .share_sel(share_sel), .bclk_in(bclk_in), .tx_fclk_in(tx_fclk_in),
    .rx_fclk_in(rx_fclk_in), .clk_oe(clk_oe), .bclk_out(bclk_out),
    .tx_fclk_out(tx_fclk_out), .rx_fclk_out(rx_fclk_out), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .tx_fclk_edge(tx_fclk_edge), .rx_fclk_edge(rx_fclk_edge));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit slv, input int bd, input int td, input int rd, input int sh);
    @(negedge clk);
    rst_n = 1'b0;
    slave_mode = slv;
    bclk_div = 8'(bd);
    tx_frame_div = 8'(td);
    rx_frame_div = 8'(rd);
    share_sel = 2'(sh);
    bclk_in = 1'b0;
    tx_fclk_in = 1'b0;
    rx_fclk_in = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk({bclk_out, tx_fclk_out, rx_fclk_out, bclk_rise, bclk_fall, tx_fclk_edge, rx_fclk_edge} == 7'd0,
        "R1", {bclk_out, tx_fclk_out, rx_fclk_out, bclk_rise, bclk_fall, tx_fclk_edge, rx_fclk_edge}, 0);
    chk(clk_oe == !slv, "R7", clk_oe, !slv);
    rst_n = 1'b1;
  endtask

  task automatic run_master(input int bd, input int td, input int rd, input int sh);
    int low = (bd + 1) / 2;
    int etd = (sh == 2) ? rd : td;
    int erd = (sh == 1 || sh == 3) ? td : rd;
    int mt = etd + 1;
    int mr = erd + 1;
    int gap = 0, txf = 0, rxf = 0, txe = 0, rxe = 0;
    bit pf = 1'b0;
    int ncyc = (bd + 1) * ((mt > mr) ? mt : mr) * 3 + 10;
    do_reset(1'b0, bd, td, rd, sh);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      gap++;
      if (bclk_rise) begin
        chk(gap == low, "R2 low phase", gap, low);
        chk(bclk_out == 1'b1 && !bclk_fall, "R3 rise level", bclk_out, 1);
        gap = 0;
      end
      if (bclk_fall) begin
        chk(gap == bd + 1 - low, "R2 high phase", gap, bd + 1 - low);
        chk(bclk_out == 1'b0, "R3 fall level", bclk_out, 0);
        gap = 0;
      end
      if (tx_fclk_edge) begin
        int e = tx_fclk_out ? mt / 2 : mt - mt / 2;
        chk(pf, "R4 tx edge follows fall", pf, 1);
        chk(txf == e, (mt == 64) ? "R9 tx frame half" : "R4 tx frame half", txf, e);
        txf = 0;
        txe++;
      end
      if (rx_fclk_edge) begin
        int e = rx_fclk_out ? mr / 2 : mr - mr / 2;
        chk(pf, "R4 rx edge follows fall", pf, 1);
        chk(txf >= 0 && rxf == e, (sh == 0) ? "R5 rx frame half" : "R6 rx frame half", rxf, e);
        rxf = 0;
        rxe++;
      end
      if (sh != 0 && (tx_fclk_edge || rx_fclk_edge))
        chk(tx_fclk_out == rx_fclk_out && tx_fclk_edge == rx_fclk_edge, "R6 shared",
            {tx_fclk_out, rx_fclk_out}, {tx_fclk_out, tx_fclk_out});
      if (bclk_fall) begin
        txf++;
        rxf++;
      end
      pf = bclk_fall;
    end
    chk(txe >= 4 && rxe >= 4, "R4 edges seen", txe, 4);
  endtask

  task automatic slave_step(input int pin, input int sh);
    bit nv;
    @(negedge clk);
    case (pin)
      0: begin bclk_in = ~bclk_in; nv = bclk_in; end
      1: begin tx_fclk_in = ~tx_fclk_in; nv = tx_fclk_in; end
      default: begin rx_fclk_in = ~rx_fclk_in; nv = rx_fclk_in; end
    endcase
    for (int k = 1; k <= 4; k++) begin
      bit exp_b, exp_t, exp_r;
      @(negedge clk);
      exp_b = (pin == 0) && (k == 3);
      exp_t = (k == 3) && ((pin == 1 && sh != 2) || (pin == 2 && sh == 2));
      exp_r = (k == 3) && ((pin == 2 && !(sh == 1 || sh == 3)) || (pin == 1 && (sh == 1 || sh == 3)));
      chk((nv ? bclk_rise : bclk_fall) == exp_b && (nv ? bclk_fall : bclk_rise) == 1'b0,
          "R7 bit strobe latency", {bclk_rise, bclk_fall}, exp_b);
      chk(tx_fclk_edge == exp_t, (pin == 0) ? "R8 tx quiet" : (sh != 0 ? "R6 slave tx" : "R7 tx latency"),
          tx_fclk_edge, exp_t);
      chk(rx_fclk_edge == exp_r, (pin == 0) ? "R8 rx quiet" : (sh != 0 ? "R6 slave rx" : "R7 rx latency"),
          rx_fclk_edge, exp_r);
      if (k == 3 && pin == 0) chk(bclk_out == nv, "R7 bit level", bclk_out, nv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int bd = 1; bd <= 12; bd++) run_master(bd, 3, 5, 0);
    for (int bd = 1; bd <= 4; bd++)
      for (int td = 1; td <= 6; td++) run_master(bd, td, td + 3, 0);
    run_master(1, 63, 63, 0);
    run_master(3, 63, 31, 0);
    for (int sh = 1; sh <= 3; sh++) run_master(2, 4, 7, sh);
    for (int sh = 0; sh <= 2; sh++) begin
      do_reset(1'b1, 1, 2, 3, sh);
      for (int i = 0; i < 4; i++) slave_step(0, sh);
      for (int i = 0; i < 2; i++) slave_step(1, sh);
      for (int i = 0; i < 2; i++) slave_step(2, sh);
    end
    @(negedge clk);
    chk(clk_oe == 1'b0, "R7 slave oe", clk_oe, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule